// File: doc/BRIEF.md
# Shift and rotate execution unit

This unit does the shift and rotate work for a 32-bit integer pipeline. Each cycle it takes the instruction's function code, the three register index fields, the shift-amount field, and the values of the two source operands. It returns the destination value and a write-enable. It covers left shifts, logical right shifts and arithmetic right shifts, and it can take the amount from the immediate field or from the low bits of the first operand. A spare bit in each right-shift encoding turns the logical right shift into a right rotate.

The all-zero left-shift encodings do no work. The unit decodes them into three flags, one for each kind of idle instruction: plain idle, issue-slot pad and hazard barrier. Later pipeline stages decide what those flags do, and none of them writes a register. All outputs are registered, so results appear one clock after the inputs are presented. A synchronous active-high reset clears every output.

Top module: `shift_unit`

## Requirements
- R1: Function code 0 shifts `rt_val` left by `sa_fld`, and function code 4 shifts it left by `rs_val`. Vacated low bits are zero.
- R2: Function code 2 with `rs_fld[0]`=0, and function code 6 with `sa_fld[0]`=0, shift `rt_val` right logically, filling the vacated upper bits with zero. Code 2 takes the amount from `sa_fld` and code 6 from `rs_val`.
- R3: Function code 3 (amount from `sa_fld`) and function code 7 (amount from `rs_val`) shift `rt_val` right and fill the vacated upper bits with copies of `rt_val[31]`.
- R4: Function code 2 with `rs_fld[0]`=1, and function code 6 with `sa_fld[0]`=1, rotate `rt_val` right by n and return (rt<<(32-n))|(rt>>n). The bits shifted out at the bottom come back in at the top, so the number of set bits does not change.
- R5: Only the low 5 bits of the amount are used. The upper 27 bits of `rs_val` have no effect on the result.
- R6: An amount of 0 returns `rt_val` unchanged for every operation, including rotate.
- R7: Function code 0 with `rs_fld`, `rt_fld` and `rd_fld` all zero is an idle instruction. If `sa_fld` is 1, `is_pad` is raised. If `sa_fld` is 3, `is_barrier` is raised. Any other `sa_fld` value raises `is_idle`. At most one of these flags is high at a time, and none of these encodings asserts `rd_wen`.
- R8: `rd_wen` is low whenever `rd_fld` is 0. For any function code other than 0, 2, 3, 4, 6 and 7, `rd_wen` is low and `rd_val` is 0.
- R9: Outputs reflect the inputs sampled at the previous rising clock edge. A synchronous reset drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| funct | input | 6 | Function code of the instruction |
| rs_fld | input | 5 | First source register index field |
| rt_fld | input | 5 | Second source register index field |
| rd_fld | input | 5 | Destination register index field |
| sa_fld | input | 5 | Immediate shift-amount field |
| rs_val | input | 32 | First operand value (variable shift amount) |
| rt_val | input | 32 | Value to be shifted |
| rd_val | output | 32 | Registered result |
| rd_wen | output | 1 | Registered destination write-enable |
| is_idle | output | 1 | Plain idle encoding seen |
| is_pad | output | 1 | Issue-slot pad encoding seen |
| is_barrier | output | 1 | Hazard-barrier encoding seen |

## Verification
The bench builds the unit at its default 32-bit width with a 5-bit amount. With these values every shift amount can be reached, so each of the eight operation kinds is swept over all 32 amounts, once with bit 31 of the operand set and once with it clear. In the variable forms the upper bits of the amount operand are random, which tests that only the low five bits are used. Directed vectors cover the idle encodings, a zero destination, unused function codes and reset.

// File: rtl/shift_pkg.sv
package shift_pkg;
  localparam int FIELD_W = 5;
  localparam int FUNC_W  = 6;

  localparam logic [FUNC_W-1:0] FN_SLL_I = 6'd0;
  localparam logic [FUNC_W-1:0] FN_SRL_I = 6'd2;
  localparam logic [FUNC_W-1:0] FN_SRA_I = 6'd3;
  localparam logic [FUNC_W-1:0] FN_SLL_V = 6'd4;
  localparam logic [FUNC_W-1:0] FN_SRL_V = 6'd6;
  localparam logic [FUNC_W-1:0] FN_SRA_V = 6'd7;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_SHL  = 3'd1,
    OP_SHRL = 3'd2,
    OP_SHRA = 3'd3,
    OP_ROTR = 3'd4
  } shop_e;
endpackage

// File: rtl/shift_decode.sv
module shift_decode
  import shift_pkg::*;
#(
  parameter int AMT_W = 5
) (
  input  logic [FUNC_W-1:0]  funct,
  input  logic [FIELD_W-1:0] rs_fld,
  input  logic [FIELD_W-1:0] rt_fld,
  input  logic [FIELD_W-1:0] rd_fld,
  input  logic [FIELD_W-1:0] sa_fld,
  input  logic [AMT_W-1:0]   rs_amt,
  output shop_e              op,
  output logic [AMT_W-1:0]   amt,
  output logic               wen,
  output logic               idle,
  output logic               pad,
  output logic               barrier
);
  logic all_zero_regs;
  assign all_zero_regs = (rs_fld == '0) && (rt_fld == '0) && (rd_fld == '0);

  always_comb begin
    op      = OP_NONE;
    amt     = '0;
    idle    = 1'b0;
    pad     = 1'b0;
    barrier = 1'b0;
    case (funct)
      FN_SLL_I: begin
        op  = OP_SHL;
        amt = sa_fld[AMT_W-1:0];
        if (all_zero_regs) begin
          if (sa_fld == FIELD_W'(1))      pad     = 1'b1;
          else if (sa_fld == FIELD_W'(3)) barrier = 1'b1;
          else                            idle    = 1'b1;
        end
      end
      FN_SRL_I: begin
        op  = rs_fld[0] ? OP_ROTR : OP_SHRL;
        amt = sa_fld[AMT_W-1:0];
      end
      FN_SRA_I: begin
        op  = OP_SHRA;
        amt = sa_fld[AMT_W-1:0];
      end
      FN_SLL_V: begin
        op  = OP_SHL;
        amt = rs_amt;
      end
      FN_SRL_V: begin
        op  = sa_fld[0] ? OP_ROTR : OP_SHRL;
        amt = rs_amt;
      end
      FN_SRA_V: begin
        op  = OP_SHRA;
        amt = rs_amt;
      end
      default: op = OP_NONE;
    endcase
  end

  assign wen = (op != OP_NONE) && (rd_fld != '0) && !(idle || pad || barrier);
endmodule

// File: rtl/shift_core.sv
module shift_core
  import shift_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int AMT_W = $clog2(XLEN)
) (
  input  shop_e             op,
  input  logic [AMT_W-1:0]  amt,
  input  logic [XLEN-1:0]   din,
  output logic [XLEN-1:0]   dout
);
  logic [AMT_W:0][XLEN-1:0] stg;
  logic sgn;

  assign sgn    = din[XLEN-1];
  assign stg[0] = din;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [XLEN-1:0] v_shl, v_shrl, v_shra, v_rotr, v_sel;
    assign v_shl  = stg[k] << S;
    assign v_shrl = stg[k] >> S;
    assign v_shra = {{S{sgn}}, stg[k][XLEN-1:S]};
    assign v_rotr = {stg[k][S-1:0], stg[k][XLEN-1:S]};
    always_comb begin
      case (op)
        OP_SHL:  v_sel = v_shl;
        OP_SHRL: v_sel = v_shrl;
        OP_SHRA: v_sel = v_shra;
        OP_ROTR: v_sel = v_rotr;
        default: v_sel = stg[k];
      endcase
    end
    assign stg[k+1] = amt[k] ? v_sel : stg[k];
  end

  assign dout = (op == OP_NONE) ? '0 : stg[AMT_W];
endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int AMT_W = $clog2(XLEN)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [FUNC_W-1:0]   funct,
  input  logic [FIELD_W-1:0]  rs_fld,
  input  logic [FIELD_W-1:0]  rt_fld,
  input  logic [FIELD_W-1:0]  rd_fld,
  input  logic [FIELD_W-1:0]  sa_fld,
  input  logic [XLEN-1:0]     rs_val,
  input  logic [XLEN-1:0]     rt_val,
  output logic [XLEN-1:0]     rd_val,
  output logic                rd_wen,
  output logic                is_idle,
  output logic                is_pad,
  output logic                is_barrier
);
  shop_e            op;
  logic [AMT_W-1:0] amt;
  logic             wen_c, idle_c, pad_c, bar_c;
  logic [XLEN-1:0]  res_c;

  shift_decode #(.AMT_W(AMT_W)) u_dec (
    .funct   (funct),
    .rs_fld  (rs_fld),
    .rt_fld  (rt_fld),
    .rd_fld  (rd_fld),
    .sa_fld  (sa_fld),
    .rs_amt  (rs_val[AMT_W-1:0]),
    .op      (op),
    .amt     (amt),
    .wen     (wen_c),
    .idle    (idle_c),
    .pad     (pad_c),
    .barrier (bar_c)
  );

  shift_core #(.XLEN(XLEN), .AMT_W(AMT_W)) u_core (
    .op   (op),
    .amt  (amt),
    .din  (rt_val),
    .dout (res_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_val     <= '0;
      rd_wen     <= 1'b0;
      is_idle    <= 1'b0;
      is_pad     <= 1'b0;
      is_barrier <= 1'b0;
    end else begin
      rd_val     <= res_c;
      rd_wen     <= wen_c;
      is_idle    <= idle_c;
      is_pad     <= pad_c;
      is_barrier <= bar_c;
    end
  end
endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [5:0]      funct,
  input logic [4:0]      rs_fld,
  input logic [4:0]      rd_fld,
  input logic [4:0]      sa_fld,
  input logic [XLEN-1:0] rs_val,
  input logic [XLEN-1:0] rt_val,
  input logic [XLEN-1:0] rd_val,
  input logic            rd_wen,
  input logic            is_idle,
  input logic            is_pad,
  input logic            is_barrier
);
  p_zero_dest_r8: assert property (@(posedge clk) disable iff (rst)
    rd_wen |-> $past(rd_fld) != 5'd0);

  p_one_flag_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({is_idle, is_pad, is_barrier}));

  p_idle_no_write_r7: assert property (@(posedge clk) disable iff (rst)
    (is_idle || is_pad || is_barrier) |-> !rd_wen);

  p_rot_keeps_ones_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(funct) == 6'd2 && $past(rs_fld[0])) |->
      $countones(rd_val) == $countones($past(rt_val)));

  p_zero_amt_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(funct) == 6'd6 && $past(rs_val[4:0]) == 5'd0) |->
      rd_val == $past(rt_val));

  p_sra_sign_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(funct) == 6'd3 && $past(sa_fld) != 5'd0) |->
      rd_val[XLEN-1] == $past(rt_val[XLEN-1]));
endmodule

bind shift_unit shift_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .funct      (funct),
  .rs_fld     (rs_fld),
  .rd_fld     (rd_fld),
  .sa_fld     (sa_fld),
  .rs_val     (rs_val),
  .rt_val     (rt_val),
  .rd_val     (rd_val),
  .rd_wen     (rd_wen),
  .is_idle    (is_idle),
  .is_pad     (is_pad),
  .is_barrier (is_barrier)
);

// File: tb/shift_unit_test.sv
module shift_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  funct = '0;
  logic [4:0]  rs_fld = '0, rt_fld = '0, rd_fld = '0, sa_fld = '0;
  logic [31:0] rs_val = '0, rt_val = '0;
  logic [31:0] rd_val;
  logic        rd_wen, is_idle, is_pad, is_barrier;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  shift_unit uut (
    .clk(clk), .rst(rst), .funct(funct), .rs_fld(rs_fld), .rt_fld(rt_fld),
    .rd_fld(rd_fld), .sa_fld(sa_fld), .rs_val(rs_val), .rt_val(rt_val),
    .rd_val(rd_val), .rd_wen(rd_wen), .is_idle(is_idle), .is_pad(is_pad),
    .is_barrier(is_barrier)
  );

  // kind: 0 shl, 1 shrl, 2 shra, 3 rotr
  function automatic logic [31:0] model(int kind, logic [31:0] v, int n);
    logic [63:0] dbl;
    case (kind)
      0: return v << n;
      1: return v >> n;
      2: return 32'($signed(v) >>> n);
      default: begin
        dbl = {v, v} >> n;
        return dbl[31:0];
      end
    endcase
  endfunction

  task automatic apply(input logic [5:0] f, input logic [4:0] rs, input logic [4:0] rt,
                       input logic [4:0] rd, input logic [4:0] sa,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    funct = f; rs_fld = rs; rt_fld = rt; rd_fld = rd; sa_fld = sa;
    rs_val = a; rt_val = b;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset rd_val", rd_val, 32'h0);
    check("R9 reset flags", {28'h0, rd_wen, is_idle, is_pad, is_barrier}, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    // sweep: all 8 forms, all 32 amounts, bit 31 clear and set
    for (int form = 0; form < 8; form++) begin
      for (int n = 0; n < 32; n++) begin
        for (int hi = 0; hi < 2; hi++) begin
          logic [31:0] opnd, a;
          logic [5:0]  f;
          logic [4:0]  rs, sa, rd;
          int kind;
          string tag;
          opnd = $urandom;
          opnd[31] = hi[0];
          a = $urandom;
          a[4:0] = 5'(n);
          rd = 5'($urandom_range(1, 31));
          rs = 5'd0;
          sa = 5'(n);
          case (form)
            0: begin f = 6'd0; kind = 0; tag = "R1 shl imm"; end
            1: begin f = 6'd4; kind = 0; tag = "R1/R5 shl var"; sa = 5'($urandom); end
            2: begin f = 6'd2; kind = 1; tag = "R2 shrl imm"; end
            3: begin f = 6'd6; kind = 1; tag = "R2/R5 shrl var";
                     sa = 5'($urandom); sa[0] = 1'b0; end
            4: begin f = 6'd3; kind = 2; tag = "R3 shra imm"; end
            5: begin f = 6'd7; kind = 2; tag = "R3/R5 shra var"; sa = 5'($urandom); end
            6: begin f = 6'd2; kind = 3; tag = "R4 rotr imm"; rs = 5'd1; end
            default: begin f = 6'd6; kind = 3; tag = "R4/R5 rotr var";
                     sa = 5'($urandom); sa[0] = 1'b1; end
          endcase
          if (f == 6'd0 || f == 6'd2 || f == 6'd3) a = $urandom;
          apply(f, rs, 5'($urandom), rd, sa, a, opnd);
          check(n == 0 ? "R6 zero amount" : tag, rd_val, model(kind, opnd, n));
          check("R8 wen on nonzero dest", {31'h0, rd_wen}, 32'h1);
        end
      end
    end

    // idle encodings
    apply(6'd0, 5'd0, 5'd0, 5'd0, 5'd1, 32'hFFFF_FFFF, 32'h0);
    check("R7 pad flag", {28'h0, rd_wen, is_idle, is_pad, is_barrier}, 32'h2);
    apply(6'd0, 5'd0, 5'd0, 5'd0, 5'd3, 32'hFFFF_FFFF, 32'h0);
    check("R7 barrier flag", {28'h0, rd_wen, is_idle, is_pad, is_barrier}, 32'h1);
    apply(6'd0, 5'd0, 5'd0, 5'd0, 5'd0, 32'h0, 32'h0);
    check("R7 idle flag sa0", {28'h0, rd_wen, is_idle, is_pad, is_barrier}, 32'h4);
    apply(6'd0, 5'd0, 5'd0, 5'd0, 5'd7, 32'h0, 32'h0);
    check("R7 idle flag sa7", {28'h0, rd_wen, is_idle, is_pad, is_barrier}, 32'h4);
    apply(6'd0, 5'd0, 5'd2, 5'd0, 5'd1, 32'h0, 32'h0);
    check("R7 not idle when rt nonzero", {28'h0, rd_wen, is_idle, is_pad, is_barrier}, 32'h0);
    apply(6'd0, 5'd0, 5'd0, 5'd4, 5'd3, 32'h0, 32'h5);
    check("R7 not idle when rd nonzero", {28'h0, rd_wen, is_idle, is_pad, is_barrier}, 32'h8);
    check("R1 shift with rd nonzero", rd_val, 32'h28);

    // zero destination and unused codes
    apply(6'd7, 5'd3, 5'd4, 5'd0, 5'd0, 32'h2, 32'h8000_0000);
    check("R8 no write to reg 0", {31'h0, rd_wen}, 32'h0);
    check("R3 value with rd 0", rd_val, 32'hE000_0000);
    for (int f = 0; f < 64; f++) begin
      if (f != 0 && f != 2 && f != 3 && f != 4 && f != 6 && f != 7) begin
        apply(6'(f), 5'd1, 5'd2, 5'd9, 5'd4, 32'h3, 32'hDEAD_BEEF);
        check("R8 unused code wen", {31'h0, rd_wen}, 32'h0);
        check("R8 unused code value", rd_val, 32'h0);
      end
    end

    // latency and synchronous reset
    apply(6'd0, 5'd0, 5'd1, 5'd5, 5'd4, 32'h0, 32'h0000_0001);
    check("R9 one-cycle result", rd_val, 32'h10);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R9 sync reset value", rd_val, 32'h0);
    check("R9 sync reset wen", {31'h0, rd_wen}, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R9 watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule